// File: doc/BRIEF.md
# Privileged Call Vector Dispatcher

This block turns a pending exception or trap index into a decision for the firmware layer of a 64-bit processor. It classifies the index, produces a handler-select code and an 8-bit call function number, checks whether the requested call is allowed in the current processor mode, and returns the faulting PC with its lowest bit cleared so that it can serve as the exception return address. It does not run handlers and it does not touch any register file.

The exception index space is linear. The lowest indices are fixed exceptions: reset, machine check, arithmetic trap, interrupt, data fault, data translation miss taken in firmware mode, data translation miss taken in native mode, unaligned access, instruction translation miss, illegal opcode and floating point disabled. Two call windows sit higher up in the space, one entry every 64 index units. The low window produces call codes 0x00 to 0x7F. The high window produces codes 0x80 to 0xFF. Codes below 0x80 are reserved for kernel mode. Any index that belongs to no fixed code and to neither window should never occur, so the block flags it as an internal error.

A request is accepted over a valid/ready handshake and the result appears in a register on the next cycle. The result stays unchanged until the consumer accepts it.

Top module: `call_vector_dispatch`

## Requirements
- R1: After reset, `out_valid` is 0, `out_sel` is 15 (none), `out_fn` is 0, and `out_priv_err` and `out_bad_idx` are both 0.
- R2: A fixed index k from 0 to 10 gives `out_sel` = k and `out_fn` = 0. The encoding is 0 reset, 1 machine check, 2 arithmetic, 3 interrupt, 4 data fault, 5 data translation miss in firmware mode, 6 data translation miss in native mode, 7 unaligned, 8 instruction translation miss, 9 illegal opcode, 10 FP disabled.
- R3: An index in [LO_BASE, HI_BASE) gives `out_fn` = (index − LO_BASE) >> 6. When the call is permitted, it also gives `out_sel` = 11 (call).
- R4: An index in [HI_BASE, HI_BASE + 128·64) gives `out_fn` = ((index − HI_BASE) >> 6) + 0x80 and `out_sel` = 11 in every mode.
- R5: A call code below 0x80 is permitted only when the mode field (status bits 7:3) is zero. Otherwise `out_priv_err` is 1 and `out_sel` is 15, while `out_fn` still carries the code.
- R6: `out_ret_addr` equals the accepted PC with bit 0 forced to 0.
- R7: An index outside the fixed codes and both windows gives `out_bad_idx` = 1, `out_sel` = 15, `out_fn` = 0 and `out_priv_err` = 0.
- R8: `in_ready` = !`out_valid` || `out_ready`. An accepted request raises `out_valid` on the next cycle. Acceptance by the consumer without a new request drops `out_valid`.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output holds its value and a new request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_idx | input | 16 | Exception index |
| in_status | input | 8 | Processor status; bits 7:3 are the mode field |
| in_pc | input | 64 | Faulting PC |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_sel | output | 4 | Handler select |
| out_fn | output | 8 | Call function code |
| out_priv_err | output | 1 | Kernel-only call requested outside kernel mode |
| out_bad_idx | output | 1 | Index maps to nothing |
| out_ret_addr | output | 64 | Return address with bit 0 cleared |

## Verification
The bench sends indices at both edges of each call window, at the last fixed code and just past it, and one past the end of the high window. A design with an off-by-one compare would misclassify one of these indices as a call or as an error. It sends low-window calls with mode values that are zero, that are non-zero, and that have only the status bits below bit 3 set. A privilege check that looks at the wrong bits would either block kernel calls or let user-mode calls through. It also offers a new request while a result is stalled, which catches a register that overwrites the held result.

// File: rtl/cvd_pkg.sv
// Shared handler-select encoding for the call vector dispatcher.
// Assumes fixed exception indices equal their select code.
package cvd_pkg;
    localparam int SEL_W     = 4;
    localparam int NUM_FIXED = 11;
    localparam logic [SEL_W-1:0] SEL_CALL = 4'd11;
    localparam logic [SEL_W-1:0] SEL_NONE = 4'd15;
    localparam logic [7:0]       FN_HIGH  = 8'h80;
endpackage

// File: rtl/cvd_classify.sv
// Classifies an exception index as a fixed vector, a low-window call,
// a high-window call or an unmapped value. Purely combinational.
// Assumes each window spans 128 entries of 2**STRIDE_SH index units.
module cvd_classify #(
    parameter int IDX_W     = 16,
    parameter int LO_BASE   = 'h2000,
    parameter int HI_BASE   = 'h4000,
    parameter int STRIDE_SH = 6
) (
    input  logic [IDX_W-1:0]         idx,
    output logic [cvd_pkg::SEL_W-1:0] sel,
    output logic [7:0]               fn,
    output logic                     is_call,
    output logic                     bad
);
    import cvd_pkg::*;

    localparam int HI_END = HI_BASE + (128 << STRIDE_SH);
    localparam logic [IDX_W-1:0] FIX_LIM = IDX_W'(NUM_FIXED);
    localparam logic [IDX_W-1:0] LO_IDX  = IDX_W'(LO_BASE);
    localparam logic [IDX_W-1:0] HI_IDX  = IDX_W'(HI_BASE);
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(HI_END);

    logic [IDX_W-1:0] lo_off, hi_off, lo_sh, hi_sh;

    // Offsets into each window, scaled down by the entry stride
    always_comb begin
        lo_off = idx - LO_IDX;
        hi_off = idx - HI_IDX;
        lo_sh  = lo_off >> STRIDE_SH;
        hi_sh  = hi_off >> STRIDE_SH;
    end

    // Range decode and code construction
    always_comb begin
        sel     = SEL_NONE;
        fn      = 8'd0;
        is_call = 1'b0;
        bad     = 1'b0;
        if (idx < FIX_LIM) begin
            sel = idx[SEL_W-1:0];
        end else if (idx >= LO_IDX && idx < HI_IDX) begin
            sel     = SEL_CALL;
            fn      = lo_sh[7:0];
            is_call = 1'b1;
        end else if (idx >= HI_IDX && idx < END_IDX) begin
            sel     = SEL_CALL;
            fn      = hi_sh[7:0] + FN_HIGH;
            is_call = 1'b1;
        end else begin
            bad = 1'b1;
        end
    end
endmodule

// File: rtl/cvd_priv_check.sv
// Decides whether a call code may run in the current mode.
// Assumes codes below 0x80 are kernel-only; kernel mode is a zero mode field.
module cvd_priv_check #(
    parameter int STAT_W = 8
) (
    input  logic              is_call,
    input  logic [7:0]        fn,
    input  logic [STAT_W-1:0] status,
    output logic              violation
);
    logic user_mode;

    // Non-kernel when any mode bit above bit 2 is set
    always_comb begin
        user_mode = |status[STAT_W-1:3];
        violation = is_call && !fn[7] && user_mode;
    end
endmodule

// File: rtl/call_vector_dispatch.sv
// Top: registered dispatch of an exception index into handler select,
// call code, privilege error and cleaned return address.
// Assumes a single-entry output register with valid/ready on both sides.
module call_vector_dispatch #(
    parameter int IDX_W     = 16,
    parameter int STAT_W    = 8,
    parameter int ADDR_W    = 64,
    parameter int LO_BASE   = 'h2000,
    parameter int HI_BASE   = 'h4000,
    parameter int STRIDE_SH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [STAT_W-1:0] in_status,
    input  logic [ADDR_W-1:0] in_pc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        out_sel,
    output logic [7:0]        out_fn,
    output logic              out_priv_err,
    output logic              out_bad_idx,
    output logic [ADDR_W-1:0] out_ret_addr
);
    import cvd_pkg::*;

    logic [SEL_W-1:0] c_sel, n_sel;
    logic [7:0]       c_fn;
    logic             c_call, c_bad, c_viol, take;

    cvd_classify #(
        .IDX_W(IDX_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE), .STRIDE_SH(STRIDE_SH)
    ) u_cls (
        .idx(in_idx), .sel(c_sel), .fn(c_fn), .is_call(c_call), .bad(c_bad)
    );

    cvd_priv_check #(.STAT_W(STAT_W)) u_priv (
        .is_call(c_call), .fn(c_fn), .status(in_status), .violation(c_viol)
    );

    // Handshake and final select with the call suppressed on violation
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
        n_sel    = c_viol ? SEL_NONE : c_sel;
    end

    // Output register: load on accept, clear valid when consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_sel      <= SEL_NONE;
            out_fn       <= 8'd0;
            out_priv_err <= 1'b0;
            out_bad_idx  <= 1'b0;
            out_ret_addr <= '0;
        end else if (take) begin
            out_valid    <= 1'b1;
            out_sel      <= n_sel;
            out_fn       <= c_fn;
            out_priv_err <= c_viol;
            out_bad_idx  <= c_bad;
            out_ret_addr <= {in_pc[ADDR_W-1:1], 1'b0};
        end else if (out_ready) begin
            out_valid    <= 1'b0;
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_sel) && $stable(out_fn)
            && $stable(out_ret_addr) && $stable(out_priv_err) && $stable(out_bad_idx));
    // R8
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
    // R5
    viol_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_priv_err |-> out_sel == SEL_NONE && !out_fn[7]);
    // R7
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bad_idx |-> out_sel == SEL_NONE && !out_priv_err);
    // R6
    ret_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_ret_addr[0]);
endmodule

// File: tb/call_vector_dispatch_test.sv
module call_vector_dispatch_test;
    localparam int LO = 'h2000;
    localparam int HI = 'h4000;
    localparam int HEND = 'h6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, out_ready = 1'b0;
    logic        in_ready, out_valid, out_priv_err, out_bad_idx;
    logic [15:0] in_idx = '0;
    logic [7:0]  in_status = '0;
    logic [63:0] in_pc = '0, out_ret_addr;
    logic [3:0]  out_sel;
    logic [7:0]  out_fn;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    call_vector_dispatch uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_idx(in_idx), .in_status(in_status), .in_pc(in_pc),
        .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
        .out_fn(out_fn), .out_priv_err(out_priv_err), .out_bad_idx(out_bad_idx),
        .out_ret_addr(out_ret_addr)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements
    function automatic void model(input int idx, input logic [7:0] st,
        output logic [3:0] sel, output logic [7:0] fn,
        output logic perr, output logic bad);
        sel = 4'd15; fn = 8'd0; perr = 1'b0; bad = 1'b0;
        if (idx < 11) sel = 4'(idx);
        else if (idx >= LO && idx < HI) begin
            fn = 8'((idx - LO) / 64);
            if (st[7:3] != 0) perr = 1'b1; else sel = 4'd11;
        end else if (idx >= HI && idx < HEND) begin
            fn = 8'((idx - HI) / 64 + 128);
            sel = 4'd11;
        end else bad = 1'b1;
    endfunction

    task automatic run_one(int idx, logic [7:0] st, logic [63:0] pc, bit stall);
        logic [3:0] es; logic [7:0] ef; logic ep, eb;
        model(idx, st, es, ef, ep, eb);
        @(negedge clk);
        chk("R8 in_ready idle", {63'd0, in_ready}, 64'd1);
        in_idx = 16'(idx); in_status = st; in_pc = pc; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 out_valid", {63'd0, out_valid}, 64'd1);
        chk(idx < 11 ? "R2 sel" : (eb ? "R7 sel" : (ep ? "R5 sel" : "R3/R4 sel")),
            {60'd0, out_sel}, {60'd0, es});
        chk(idx >= HI ? "R4 fn" : "R3 fn", {56'd0, out_fn}, {56'd0, ef});
        chk("R5 priv", {63'd0, out_priv_err}, {63'd0, ep});
        chk("R7 bad", {63'd0, out_bad_idx}, {63'd0, eb});
        chk("R6 ret", out_ret_addr, {pc[63:1], 1'b0});
        if (stall) begin
            chk("R8 in_ready stalled", {63'd0, in_ready}, 64'd0);
            in_idx = 16'(HI + 64); in_status = 8'hF8; in_pc = ~pc; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R9 held sel", {60'd0, out_sel}, {60'd0, es});
            chk("R9 held fn", {56'd0, out_fn}, {56'd0, ef});
            chk("R9 held ret", out_ret_addr, {pc[63:1], 1'b0});
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R8 drained", {63'd0, out_valid}, 64'd0);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 valid", {63'd0, out_valid}, 64'd0);
        chk("R1 sel", {60'd0, out_sel}, 64'd15);
        chk("R1 fn", {56'd0, out_fn}, 64'd0);
        chk("R1 flags", {62'd0, out_priv_err, out_bad_idx}, 64'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 11; k++) run_one(k, 8'h00, 64'h1000 + 64'(k), 1'b0);
        run_one(11, 8'h00, 64'h3, 1'b0);
        run_one(LO - 1, 8'h00, 64'h5, 1'b0);
        run_one(LO, 8'h00, 64'h7, 1'b1);
        run_one(LO, 8'h08, 64'h9, 1'b0);
        run_one(LO, 8'h07, 64'hB, 1'b0);
        run_one(HI - 1, 8'h00, 64'hD, 1'b0);
        run_one(HI - 1, 8'hF8, 64'hF, 1'b0);
        run_one(HI, 8'hF8, 64'h11, 1'b1);
        run_one(HEND - 1, 8'h18, 64'h13, 1'b0);
        run_one(HEND, 8'h00, 64'h15, 1'b0);
        run_one(16'hFFFF, 8'h00, 64'h17, 1'b0);
        for (int n = 0; n < 300; n++) begin
            int idx;
            int r;
            r = int'($urandom % 4);
            case (r)
                0: idx = int'($urandom % 11);
                1: idx = LO + int'($urandom % (HI - LO));
                2: idx = HI + int'($urandom % (HEND - HI));
                default: idx = int'($urandom % 65536);
            endcase
            run_one(idx, 8'($urandom), {$urandom, $urandom}, 1'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule